// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block is the digital half of a 12-bit successive-approximation converter. A single external convert input and an external bit clock drive it. It steps an approximation register using one comparator bit and streams the result on a serial data pin that can be released to high impedance. It also reports whether the front end is in sample or hold and whether the converter is in its low-power state. The trial code it presents to the (external) capacitor array is visible as an output, so a bench or a behavioural comparator can compute the comparator bit from a known input level.

The convert input alone picks what happens in each frame, by when it moves relative to the 13th bit clock. Held low, it yields a normal MSB-first readout followed by power-down. Raised early and left high, it gives a plain readout with the converter staying powered. Dropped again before clock 13, it aborts the conversion. Dropped just after clock 13 has opened, it makes the block resend the word LSB first. Every sequencer decision is taken on the rising edge of the bit clock. The data pin is relaunched on the falling edge, so a receiver samples it on the rising edge.

Top module: `adc_sar_seq`

## Requirements
- R1: While rst_ni is low, and after its release until a frame starts, data_oe_o is 0, hold_o is 0 (sample) and pwr_dn_o is 0.
- R2: hold_o is combinational on conv_i. In idle, after conv_i was sampled high on the last rising edge, conv_i going low raises hold_o at once, and that rising edge starts a frame; the clock it opens is clock 1. In power-down or LSB-first replay, conv_i going high drops hold_o at once. While hold_o is 0, pwr_dn_o is 0 after the next rising edge.
- R3: data_oe_o is 1 from clock 1 through clock 13 of a frame and data_o is 0 in clock 1. Clocks 2 to 13 carry result bits 11 down to 0 of the conversion in progress. A conversion never lasts more than 13 clocks.
- R4: trial_o is two's complement and reads 0x000 in clock 1. At the rising edge that opens clock k (k = 2..13), bit 13-k is kept if comp_i is 1 and cleared if it is 0. The next lower bit is then set as a trial, and bits decided earlier never change again within the frame.
- R5: The result is two's complement. With a comparator that reports input >= trial_o, an input of 2047 or above yields 0x7FF, 0 yields 0x000, -1 yields 0xFFF and -2048 or below yields 0x800.
- R6: data_o and data_oe_o change only on falling edges of clk_i.
- R7: If conv_i is sampled low at every edge from the start through the edge opening clock 13, pwr_dn_o rises in clock 13 while bit 0 is still shown. The pin is released from clock 14, and power-down lasts until conv_i is sampled high.
- R8: If conv_i is sampled high at the edges opening clocks 13 and 14, the block is idle, in sample mode, powered and released from clock 14.
- R9: If conv_i was sampled high during the conversion and high at the edge opening clock 13, then low at the edge opening clock 14, clocks 14..24 carry bits 1..11. After that data_o stays 0. pwr_dn_o is 1 from clock 14. conv_i sampled high releases the pin and returns to idle.
- R10: If conv_i was sampled high during the conversion and is sampled low at the edge opening any clock from 2 to 13, the pin is released from that clock and pwr_dn_o rises. The block stays in power-down until conv_i is sampled high.
- R11: conv_i held low from reset does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert control |
| comp_i | input | 1 | Comparator: 1 when input >= trial_o |
| trial_o | output | 12 | Trial code for the capacitor array, two's complement |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Serial data drive enable, 0 = high impedance |
| hold_o | output | 1 | 1 = hold, 0 = sample |
| pwr_dn_o | output | 1 | 1 = low-power state |

## Verification
Every sequencer decision follows the rising edge at which conv_i is sampled. Pin values follow half a clock later, so the bench reads the pin 1 ns before the next rising edge and expects there the bit of the clock just opened. hold_o depends on conv_i without a register, so it is compared in the same window against the live convert level. pwr_dn_o is compared there too, one edge after the deciding sample. The pin is also read 1 ns after each rising edge to show it did not move across that edge.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_PDN    = 2'd2,
    ST_REPLAY = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = $clog2(2 * RES_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             conv_q_o,
  output logic             pwr_o,
  output logic             start_o,
  output logic             step_o
);
  localparam int LAST_CLK   = RES_W + 1;
  localparam int REPLAY_END = 2 * RES_W + 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             hi_q, pwr_q, pd_end_q, conv_q;
  logic             in_conv, abort;

  assign nxt     = cnt_q + CNT_W'(1);
  assign in_conv = nxt <= CNT_W'(LAST_CLK);
  assign abort   = hi_q && !conv_i;
  assign start_o = (state_q == ST_IDLE) && conv_q && !conv_i;
  assign step_o  = (state_q == ST_CONV) && !pd_end_q && in_conv && !abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hi_q     <= 1'b0;
      pwr_q    <= 1'b0;
      pd_end_q <= 1'b0;
      conv_q   <= 1'b0;
    end else begin
      conv_q <= conv_i;
      case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_CONV;
          cnt_q   <= CNT_W'(1);
          hi_q    <= 1'b0;
        end
        ST_CONV: begin
          if (conv_i) hi_q <= 1'b1;
          if (pd_end_q) begin
            pd_end_q <= 1'b0;
            state_q  <= conv_i ? ST_IDLE : ST_PDN;
            if (conv_i) pwr_q <= 1'b0;
          end else if (in_conv && abort) begin
            state_q <= ST_PDN;
            pwr_q   <= 1'b1;
          end else if (in_conv) begin
            cnt_q <= nxt;
            if (nxt == CNT_W'(LAST_CLK) && !conv_i) begin
              pwr_q    <= 1'b1;
              pd_end_q <= 1'b1;
            end
          end else if (!conv_i) begin
            state_q <= ST_REPLAY;
            cnt_q   <= nxt;
            pwr_q   <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_PDN: if (conv_i) begin
          state_q <= ST_IDLE;
          pwr_q   <= 1'b0;
        end
        ST_REPLAY: begin
          if (conv_i) begin
            state_q <= ST_IDLE;
            pwr_q   <= 1'b0;
          end else if (cnt_q != CNT_W'(REPLAY_END)) begin
            cnt_q <= nxt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign conv_q_o = conv_q;
  assign pwr_o    = pwr_q;

  // power-down is only ever entered on a low convert sample
  assert_pdn_on_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q) |-> !$past(conv_i));
  // a high convert sample always ends the low-power state
  assert_pdn_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q && conv_i) |=> !pwr_q);
  // conversion never runs past the last bit clock
  assert_conv_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && cnt_q == CNT_W'(LAST_CLK)) |=> (state_q != ST_CONV));
endmodule

// File: rtl/adc_seq_approx.sv
`timescale 1ns/1ps
module adc_seq_approx #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] code_o
);
  localparam logic [RES_W-1:0] TOP = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] u_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q    <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      u_q    <= TOP;
      mask_q <= TOP;
    end else if (step_i) begin
      u_q    <= (u_q & ~mask_q) | (comp_i ? mask_q : '0) | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  // offset binary inside, two's complement outside
  assign code_o = {~u_q[RES_W-1], u_q[RES_W-2:0]};

  // decided bits stay fixed
  assert_decided_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (((u_q ^ $past(u_q)) & ~($past(mask_q) | ($past(mask_q) >> 1))) == '0));
endmodule

// File: rtl/adc_seq_out.sv
`timescale 1ns/1ps
module adc_seq_out
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = $clog2(2 * RES_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_state_e       state_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [RES_W-1:0] code_i,
  output logic             data_o,
  output logic             data_oe_o
);
  localparam int LAST_CLK = RES_W + 1;
  localparam int IDX_W    = $clog2(RES_W);

  logic [CNT_W-1:0] fwd_idx, rev_idx;
  logic             nxt_d, nxt_oe;

  assign fwd_idx = CNT_W'(LAST_CLK) - cnt_i;
  assign rev_idx = cnt_i - CNT_W'(LAST_CLK);

  always_comb begin
    nxt_d  = 1'b0;
    nxt_oe = 1'b0;
    case (state_i)
      ST_CONV: begin
        nxt_oe = 1'b1;
        if (cnt_i != CNT_W'(1)) nxt_d = code_i[fwd_idx[IDX_W-1:0]];
      end
      ST_REPLAY: begin
        nxt_oe = 1'b1;
        if (cnt_i <= CNT_W'(2 * RES_W)) nxt_d = code_i[rev_idx[IDX_W-1:0]];
      end
      default: ;
    endcase
  end

  // launch on the falling edge, receiver samples on the rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= 1'b0;
      data_oe_o <= 1'b0;
    end else begin
      data_o    <= nxt_d;
      data_oe_o <= nxt_oe;
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
`timescale 1ns/1ps
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             data_o,
  output logic             data_oe_o,
  output logic             hold_o,
  output logic             pwr_dn_o
);
  localparam int CNT_W = $clog2(2 * RES_W + 2);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             conv_q, start, step;
  logic [RES_W-1:0] code;

  adc_seq_ctrl #(.RES_W(RES_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .conv_i   (conv_i),
    .state_o  (state),
    .cnt_o    (cnt),
    .conv_q_o (conv_q),
    .pwr_o    (pwr_dn_o),
    .start_o  (start),
    .step_o   (step)
  );

  adc_seq_approx #(.RES_W(RES_W)) u_approx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .step_i  (step),
    .comp_i  (comp_i),
    .code_o  (code)
  );

  adc_seq_out #(.RES_W(RES_W), .CNT_W(CNT_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .cnt_i     (cnt),
    .code_i    (code),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign trial_o = code;

  // track/hold follows convert without waiting for the clock
  always_comb begin
    case (state)
      ST_IDLE: hold_o = conv_q & ~conv_i;
      ST_CONV: hold_o = 1'b1;
      default: hold_o = ~conv_i;
    endcase
  end

  assert_sample_powered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |=> !pwr_dn_o);
endmodule

// File: tb/tb_adc_sar_seq.sv
`timescale 1ns/1ps
module tb_adc_sar_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0;
  logic        comp;
  logic [11:0] trial;
  logic        data, data_oe, hold, pwr_dn;
  int          vin = 0;

  always #2.5 clk = ~clk;

  adc_sar_seq #(.RES_W(12)) dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .comp_i(comp),
    .trial_o(trial), .data_o(data), .data_oe_o(data_oe),
    .hold_o(hold), .pwr_dn_o(pwr_dn)
  );

  // behavioural comparator: input at or above the trial level
  assign comp = (vin >= int'($signed(trial)));

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0, run_chk = 0;
  string cur_req = "R1";
  bit    rx_q[$];

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int clamp12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  // reference model: 0 idle, 1 converting, 2 low power, 3 reverse replay
  int m_mode = 0, m_clk = 0, m_code = 0;
  bit m_hi = 0, m_pwr = 0, m_cq = 0, m_pdend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_clk = 0; m_hi = 0; m_pwr = 0; m_cq = 0; m_pdend = 0;
    end else begin
      case (m_mode)
        0: if (m_cq && !conv) begin
             m_mode = 1; m_clk = 1; m_hi = 0; m_code = clamp12(vin) & 12'hFFF;
           end
        1: begin
             if (m_pdend) begin
               m_pdend = 0;
               if (conv) begin m_mode = 0; m_pwr = 0; end else m_mode = 2;
             end else if (m_clk + 1 <= 13 && m_hi && !conv) begin
               m_mode = 2; m_pwr = 1;
             end else if (m_clk + 1 <= 13) begin
               m_clk++;
               if (m_clk == 13 && !conv) begin m_pwr = 1; m_pdend = 1; end
             end else if (!conv) begin
               m_mode = 3; m_clk = 14; m_pwr = 1;
             end else m_mode = 0;
             if (conv) m_hi = 1;
           end
        2: if (conv) begin m_mode = 0; m_pwr = 0; end
        default: if (conv) begin m_mode = 0; m_pwr = 0; end
                 else if (m_clk < 25) m_clk++;
      endcase
      m_cq = conv;
    end
  end

  function automatic int exp_oe();
    return (m_mode == 1 || m_mode == 3) ? 1 : 0;
  endfunction

  function automatic int exp_data();
    if (m_mode == 1) return (m_clk == 1) ? 0 : ((m_code >> (13 - m_clk)) & 1);
    if (m_mode == 3) return (m_clk <= 24) ? ((m_code >> (m_clk - 13)) & 1) : 0;
    return 0;
  endfunction

  function automatic int exp_hold();
    if (m_mode == 0) return (m_cq && !conv) ? 1 : 0;
    if (m_mode == 1) return 1;
    return conv ? 0 : 1;
  endfunction

  // per-cycle comparison; pin stability read just after each rising edge
  initial begin
    logic pd, poe;
    bit   have = 0;
    forever begin
      @(posedge clk);
      #1;
      if (run_chk && have) begin
        chk("R6", int'(data_oe), int'(poe), "oe moved at rising edge");
        if (poe) chk("R6", int'(data), int'(pd), "data moved at rising edge");
      end
      #3;
      if (run_chk) begin
        chk("R2", int'(hold), exp_hold(), "hold_o");
        chk((m_mode == 2) ? "R10" : "R7", int'(pwr_dn), int'(m_pwr), "pwr_dn_o");
        chk(cur_req, int'(data_oe), exp_oe(), "data_oe_o");
        if (exp_oe() == 1) chk(cur_req, int'(data), exp_data(), "data_o");
        if (m_mode == 1 && m_clk == 1) chk("R4", int'(trial), 0, "trial_o in clock 1");
        pd = data; poe = data_oe; have = 1;
        if (data_oe) rx_q.push_back(data);
      end
    end
  end

  task automatic run(input string req, input int v, input int n, input logic [63:0] pat);
    cur_req = req;
    vin = v;
    @(negedge clk); #0.5 conv = 1'b1;
    rx_q.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5 conv = pat[i];
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #0.5 conv = 1'b1;
    end
  endtask

  function automatic int fwd_word(input int first);
    int w = 0;
    for (int i = 0; i < 12; i++) w = (w << 1) | int'(rx_q[first + i]);
    return w;
  endfunction

  task automatic frame_check(input string req, input int v, input int exp_word, input int n,
                             input logic [63:0] pat);
    run(req, v, n, pat);
    chk(req, rx_q.size(), 13, "bits received");
    if (rx_q.size() == 13) begin
      chk("R3", int'(rx_q[0]), 0, "clock 1 bit");
      chk("R5", fwd_word(1), exp_word, "received word");
    end
  endtask

  initial begin
    #12;
    chk("R1", int'(data_oe), 0, "oe in reset");
    chk("R1", int'(hold), 0, "hold in reset");
    chk("R1", int'(pwr_dn), 0, "pwr in reset");
    @(negedge clk); rst_n = 1'b1;
    run_chk = 1;
    cur_req = "R11";
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R11", int'(data_oe), 0, "no frame with convert held low");

    // R8 normal readout, convert raised in clock 3
    frame_check("R8", 2047, 12'h7FF, 16, 64'hFFFC);
    frame_check("R8", 0, 12'h000, 14, 64'h3FFC);
    frame_check("R8", -1, 12'hFFF, 14, 64'h3FFC);
    frame_check("R8", 1234, 12'h4D2, 16, 64'hFFFC);
    // R7 held low through the frame
    frame_check("R7", -2048, 12'h800, 16, 64'h0);
    frame_check("R7", 5000, 12'h7FF, 16, 64'h0);
    frame_check("R7", -5000, 12'h800, 16, 64'h0);

    // R9 reverse replay
    run("R9", -777, 31, 64'h1FFC);
    chk("R9", rx_q.size(), 31, "bits received in replay");
    if (rx_q.size() == 31) begin
      int w = 0;
      for (int j = 0; j < 12; j++) w |= int'(rx_q[12 + j]) << j;
      chk("R9", w, 12'hCF7, "LSB-first word");
      chk("R9", fwd_word(1), 12'hCF7, "MSB-first word before replay");
      for (int j = 24; j < 31; j++) chk("R9", int'(rx_q[j]), 0, "low after replay");
    end
    chk("R9", int'(data_oe), 0, "released after convert rises");

    // R10 abort in clock 6 and at clock 13
    run("R10", 1500, 10, 64'h1C);
    chk("R10", rx_q.size(), 5, "bits before abort at clock 6");
    if (rx_q.size() == 5) chk("R10", (fwd_word(0) >> 7) & 15, (1500 >> 8) & 15, "bits before abort");
    run("R10", -300, 16, 64'hFFC);
    chk("R10", rx_q.size(), 12, "bits before abort at clock 13");

    frame_check("R3", 7, 12'h007, 16, 64'hFFFC);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule